// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround SRAM Controller

This block is a synchronous single-port memory that accepts one command on every clock and needs no idle cycle when the bus turns from reads to writes. A read is flow-through: the word at the address clocked on an edge is on `rdata` during the cycle that follows that edge. A write is late by one cycle: the address and byte-lane enables are taken on one enabled edge, and the data on the next enabled edge. A write followed at once by a read therefore keeps the bus busy on every cycle.

Each word is made of `NB` lanes. A lane holds `BYTE_W` data bits with a parity bit above them. A command either loads a new address or continues a four-beat burst from the last loaded address. The access type is fixed when the burst is loaded. A clock-enable input stretches the current cycle. A sleep input freezes all access. An output-enable input can only narrow the window in which `rdata_vld` is high.

Top module: `ztsram_ft`

## Requirements
- R1: A load edge (`burst_go`=0) selects the block only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. On any other load, `rdata_vld` is 0 through the cycle after that edge, and it stays 0 until the next selecting load.
- R2: An edge with `clk_en_n`=1 is ignored. Address, access type, pending write and selection all hold, so `rdata` and `rdata_vld` keep their values. Such an edge does not deselect the block.
- R3: After a selected read load, `rdata` holds the stored word at the loaded address during the next cycle, with `rdata_vld`=1, provided `drive_n` is 0 and the cycle is not the first one after a deselect.
- R4: On a selected write, `wdata` is written on the next enabled edge after the address edge. `rdata_vld` is 0 during the data cycle.
- R5: Lane i of a word is bits [9i+8:9i]: data in bits [9i+7:9i] and parity in bit 9i+8. `lane_wr_n[i]`=0 on the address edge of a write writes lane i. If every `lane_wr_n` bit is 1, the write is aborted and no lane changes.
- R6: The level of `wr_req_n` on the load edge sets the access type of every beat in that burst. On continue edges `wr_req_n` is ignored.
- R7: Beat n of a burst (n = 0..3, counted from the load) uses the loaded address with its low two bits replaced. With `INTERLEAVE`=0 (the default) they are (start + n) mod 4; with `INTERLEAVE`=1 they are start XOR n. The upper bits do not change.
- R8: On the first cycle after a load that selects the block from the deselected state, `rdata_vld` is 0. Reset leaves the block deselected.
- R9: A read of the address written on the previous enabled edge returns the newly written data.
- R10: `rdata_vld` is 0 whenever `drive_n` is 1. `drive_n`=0 never makes `rdata_vld` 1 in a write cycle or a deselected cycle.
- R11: A continue edge while deselected writes nothing and gives no output. The burst address still advances.
- R12: While `sleep` is 1, `rdata_vld` is 0 and no edge reads or writes memory. An edge with `sleep`=1 deselects the block and drops any pending write. The stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Edge qualifier, active low |
| sel1_n | input | 1 | Select term, active low |
| sel2 | input | 1 | Select term, active high |
| sel3_n | input | 1 | Select term, active low |
| wr_req_n | input | 1 | Write request, active low, taken on load edges |
| lane_wr_n | input | NB | Per-lane write enables, active low |
| burst_go | input | 1 | 1 continues the burst, 0 loads `addr` |
| addr | input | AW | Word address |
| wdata | input | NB*(BYTE_W+1) | Write data, one enabled edge after its address |
| drive_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep request, active high, asynchronous to outputs |
| rdata | output | NB*(BYTE_W+1) | Word at the current burst address |
| rdata_vld | output | 1 | High when `rdata` is a valid read result |

## Verification
The bench targets the cycle after a selecting load from the deselected state. A design that does not mask that cycle raises `rdata_vld` one cycle early. It also targets a read of the address written on the edge just before. A design that reads the array before committing the pending write returns stale data there. Clock-enable stalls are placed between a write address and its data. A design that commits on a disabled edge writes whatever `wdata` holds during the stall. Other directed cases cover: continue beats with `wr_req_n` toggled, where a design that samples the access type per beat flips between read and write; aborted and single-lane writes; continues while deselected; and sleep with a command present. A mixed random phase compares every valid read against a reference copy of the memory.

// File: rtl/ztsram_pkg.sv
`timescale 1ns/1ps
package ztsram_pkg;
   localparam int BEAT_W = 2;

   typedef struct packed {
      logic load;     // 1: take a new address, 0: continue burst
      logic chip_on;  // all three select terms true
      logic wr;       // write requested on this edge
   } cmd_t;
endpackage

// File: rtl/ztsram_burst.sv
`timescale 1ns/1ps
module ztsram_burst
   import ztsram_pkg::*;
#(
   parameter int AW         = 6,
   parameter int INTERLEAVE = 0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          load,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] cur_addr
);
   logic [AW-1:0]     base_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
      end else if (step) begin
         if (load) begin
            base_q <= addr_in;
            beat_q <= '0;
         end else begin
            beat_q <= beat_q + BEAT_W'(1);
         end
      end
   end

   generate
      if (INTERLEAVE != 0) begin : g_xor
         assign low = base_q[BEAT_W-1:0] ^ beat_q;
      end else begin : g_lin
         assign low = base_q[BEAT_W-1:0] + beat_q;
      end
   endgenerate

   assign cur_addr = {base_q[AW-1:BEAT_W], low};
endmodule

// File: rtl/ztsram_ctl.sv
`timescale 1ns/1ps
module ztsram_ctl
   import ztsram_pkg::*;
#(
   parameter int NB = 2
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          sleep,
   input  cmd_t          cmd,
   input  logic [NB-1:0] lane_wr_n,
   input  logic          drive_n,
   output logic          sel_q,
   output logic          commit,
   output logic [NB-1:0] commit_be,
   output logic          rd_vld
);
   logic          wr_q, fresh_q, pend_q;
   logic [NB-1:0] be_q;
   logic          sel_nx, wr_nx, pend_nx;
   logic [NB-1:0] be_nx;

   always_comb begin
      sel_nx  = cmd.load ? cmd.chip_on : sel_q;
      wr_nx   = cmd.load ? cmd.wr      : wr_q;
      be_nx   = ~lane_wr_n;
      pend_nx = sel_nx & wr_nx & (|be_nx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= 1'b0;
         wr_q    <= 1'b0;
         fresh_q <= 1'b0;
         pend_q  <= 1'b0;
         be_q    <= '0;
      end else if (sleep) begin
         sel_q   <= 1'b0;
         fresh_q <= 1'b0;
         pend_q  <= 1'b0;
      end else if (step) begin
         sel_q   <= sel_nx;
         wr_q    <= wr_nx;
         fresh_q <= cmd.load & cmd.chip_on & ~sel_q;
         pend_q  <= pend_nx;
         be_q    <= be_nx;
      end
   end

   assign commit    = step & pend_q;
   assign commit_be = be_q;
   assign rd_vld    = sel_q & ~wr_q & ~fresh_q & ~drive_n & ~sleep;
endmodule

// File: rtl/ztsram_lanes.sv
`timescale 1ns/1ps
module ztsram_lanes #(
   parameter int AW     = 6,
   parameter int NB     = 2,
   parameter int LANE_W = 9
)(
   input  logic             clk,
   input  logic             we,
   input  logic [NB-1:0]    be,
   input  logic [AW-1:0]    addr,
   input  logic [NB*LANE_W-1:0] wdata,
   output logic [NB*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we && be[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
      end
      assign rdata[i*LANE_W +: LANE_W] = mem[addr];
   end
endmodule

// File: rtl/ztsram_ft.sv
`timescale 1ns/1ps
module ztsram_ft
   import ztsram_pkg::*;
#(
   parameter int AW         = 6,
   parameter int NB         = 2,
   parameter int BYTE_W     = 8,
   parameter int INTERLEAVE = 0
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clk_en_n,
   input  logic                       sel1_n,
   input  logic                       sel2,
   input  logic                       sel3_n,
   input  logic                       wr_req_n,
   input  logic [NB-1:0]              lane_wr_n,
   input  logic                       burst_go,
   input  logic [AW-1:0]              addr,
   input  logic [NB*(BYTE_W+1)-1:0]   wdata,
   input  logic                       drive_n,
   input  logic                       sleep,
   output logic [NB*(BYTE_W+1)-1:0]   rdata,
   output logic                       rdata_vld
);
   localparam int LANE_W = BYTE_W + 1;

   generate
      if (AW < BEAT_W + 1) begin : g_bad_aw
         initial $error("ztsram_ft: AW must be at least %0d", BEAT_W + 1);
      end
      if (NB < 1 || BYTE_W < 1) begin : g_bad_lane
         initial $error("ztsram_ft: NB and BYTE_W must be positive");
      end
   endgenerate

   cmd_t          cmd;
   logic          step, commit, cur_sel;
   logic [NB-1:0] commit_be;
   logic [AW-1:0] cur_addr;

   assign step        = ~clk_en_n & ~sleep;
   assign cmd.load    = ~burst_go;
   assign cmd.chip_on = ~sel1_n & sel2 & ~sel3_n;
   assign cmd.wr      = ~wr_req_n;

   ztsram_burst #(.AW(AW), .INTERLEAVE(INTERLEAVE)) u_burst (
      .clk(clk), .rst_n(rst_n), .step(step), .load(cmd.load),
      .addr_in(addr), .cur_addr(cur_addr)
   );

   ztsram_ctl #(.NB(NB)) u_ctl (
      .clk(clk), .rst_n(rst_n), .step(step), .sleep(sleep), .cmd(cmd),
      .lane_wr_n(lane_wr_n), .drive_n(drive_n), .sel_q(cur_sel),
      .commit(commit), .commit_be(commit_be), .rd_vld(rdata_vld)
   );

   ztsram_lanes #(.AW(AW), .NB(NB), .LANE_W(LANE_W)) u_lanes (
      .clk(clk), .we(commit), .be(commit_be), .addr(cur_addr),
      .wdata(wdata), .rdata(rdata)
   );
endmodule

// File: rtl/ztsram_ft_chk.sv
`timescale 1ns/1ps
module ztsram_ft_chk #(
   parameter int DW = 18
)(
   input logic          clk,
   input logic          rst_n,
   input logic          clk_en_n,
   input logic          sel1_n,
   input logic          sel2,
   input logic          sel3_n,
   input logic          wr_req_n,
   input logic          burst_go,
   input logic          drive_n,
   input logic          sleep,
   input logic [DW-1:0] rdata,
   input logic          rdata_vld,
   input logic          cur_sel
);
   logic go, on;
   assign go = ~clk_en_n & ~sleep;
   assign on = ~sel1_n & sel2 & ~sel3_n;

   // R1
   desel_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !burst_go && !on) |=> !rdata_vld);

   // R4
   wr_data_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !burst_go && on && !wr_req_n) |=> !rdata_vld);

   // R8
   emerge_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !burst_go && on && !cur_sel) |=> !rdata_vld);

   // R2
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en_n && !sleep) |=> $stable(rdata));

   // R12
   sleep_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !rdata_vld);

   // R10
   drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive_n |-> !rdata_vld);
endmodule

bind ztsram_ft ztsram_ft_chk #(.DW(NB*(BYTE_W+1))) u_chk (
   .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n),
   .sel2(sel2), .sel3_n(sel3_n), .wr_req_n(wr_req_n), .burst_go(burst_go),
   .drive_n(drive_n), .sleep(sleep), .rdata(rdata), .rdata_vld(rdata_vld),
   .cur_sel(cur_sel)
);

// File: tb/ztsram_ft_bench.sv
`timescale 1ns/1ps
module ztsram_ft_bench;
   localparam logic [2:0] ON = 3'b010; // {sel1_n, sel2, sel3_n}

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        clk_en_n = 1'b0, sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
   logic        wr_req_n = 1'b1, burst_go = 1'b0, drive_n = 1'b0, sleep = 1'b0;
   logic [1:0]  lane_wr_n = 2'b11;
   logic [5:0]  addr = '0;
   logic [17:0] wdata = '0;
   logic [17:0] rdata;
   logic        rdata_vld;

   int n_chk = 0, n_bad = 0;

   // bench-side model of the requirements
   bit          m_sel, m_wr, m_fresh, m_pw;
   bit [1:0]    m_be, m_cnt;
   bit [5:0]    m_base;
   logic [17:0] ref_mem [int];

   always #4 clk = ~clk;

   ztsram_ft u_ztsram_ft (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n),
      .sel2(sel2), .sel3_n(sel3_n), .wr_req_n(wr_req_n), .lane_wr_n(lane_wr_n),
      .burst_go(burst_go), .addr(addr), .wdata(wdata), .drive_n(drive_n),
      .sleep(sleep), .rdata(rdata), .rdata_vld(rdata_vld)
   );

   function automatic logic [5:0] m_addr();
      return {m_base[5:2], 2'(m_base[1:0] + m_cnt)};
   endfunction

   function automatic logic [17:0] pat(input int i);
      return {6'(i) ^ 6'h2A, 6'(i * 5), ~6'(i)};
   endfunction

   task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic observe(input string tag);
      bit ev;
      ev = m_sel && !m_wr && !m_fresh && !drive_n && !sleep;
      chk({tag, " rdata_vld"}, 18'(rdata_vld), 18'(ev));
      if (ev && ref_mem.exists(int'(m_addr())))
         chk({tag, " rdata"}, rdata, ref_mem[int'(m_addr())]);
   endtask

   task automatic step(input string tag, input bit c_n, input logic [2:0] ens,
                       input bit wr, input logic [1:0] bw, input bit adv,
                       input logic [5:0] ad, input logic [17:0] d);
      logic [17:0] t;
      int k;
      bit chip;
      clk_en_n = c_n; {sel1_n, sel2, sel3_n} = ens; wr_req_n = !wr;
      lane_wr_n = bw; burst_go = adv; addr = ad; wdata = d;
      @(posedge clk);
      if (sleep) begin
         m_sel = 0; m_pw = 0; m_fresh = 0;
      end else if (!c_n) begin
         if (m_pw) begin
            k = int'(m_addr());
            t = ref_mem.exists(k) ? ref_mem[k] : '0;
            for (int i = 0; i < 2; i++) if (m_be[i]) t[i*9 +: 9] = d[i*9 +: 9];
            ref_mem[k] = t;
         end
         chip = (ens == ON);
         if (!adv) begin
            m_fresh = chip && !m_sel; m_sel = chip; m_wr = wr;
            m_base = ad; m_cnt = 0;
         end else begin
            m_fresh = 0; m_cnt = m_cnt + 2'd1;
         end
         m_pw = m_sel && m_wr && (bw != 2'b11);
         m_be = ~bw;
      end
      @(negedge clk);
      observe(tag);
   endtask

   task automatic t_reset();
      chk("R8 reset rdata_vld", 18'(rdata_vld), 18'd0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < 64; i++) step("R4", 0, ON, 1, 2'b00, 0, 6'(i), pat(i - 1));
      for (int i = 0; i < 64; i++) step("R3", 0, ON, 0, 2'b00, 0, 6'(i), pat(63));
   endtask

   task automatic t_lanes();
      step("R5", 0, ON, 1, 2'b10, 0, 6'd5, '0);
      step("R5", 0, ON, 1, 2'b11, 0, 6'd6, 18'h3_0155);
      step("R5", 0, ON, 1, 2'b01, 0, 6'd7, 18'h1_2AAA);
      step("R5", 0, ON, 0, 2'b00, 0, 6'd5, 18'h2_5A5A);
      step("R5", 0, ON, 0, 2'b00, 0, 6'd6, '0);
      step("R5", 0, ON, 0, 2'b00, 0, 6'd7, '0);
   endtask

   task automatic t_raw();
      step("R9", 0, ON, 1, 2'b00, 0, 6'd9, '0);
      step("R9", 0, ON, 0, 2'b00, 0, 6'd9, 18'h3_C3C5);
      step("R9", 0, ON, 1, 2'b00, 0, 6'd9, '0);
      step("R9", 0, ON, 0, 2'b11, 0, 6'd9, 18'h0_1E1E);
   endtask

   task automatic t_drive();
      drive_n = 1'b1;
      step("R10", 0, ON, 0, 2'b11, 0, 6'd10, '0);
      step("R10", 0, ON, 0, 2'b11, 0, 6'd11, '0);
      drive_n = 1'b0;
      #1 observe("R10 reopen");
      step("R10", 0, ON, 0, 2'b11, 0, 6'd12, '0);
   endtask

   task automatic t_desel();
      step("R1 sel1_n", 0, 3'b110, 0, 2'b11, 0, 6'd13, '0);
      step("R8", 0, ON, 0, 2'b11, 0, 6'd14, '0);
      step("R3", 0, ON, 0, 2'b11, 0, 6'd15, '0);
      step("R1 sel2", 0, 3'b000, 0, 2'b11, 0, 6'd16, '0);
      step("R8", 0, ON, 0, 2'b11, 0, 6'd17, '0);
      step("R1 sel3_n", 0, 3'b011, 0, 2'b11, 0, 6'd18, '0);
      step("R8", 0, ON, 0, 2'b11, 0, 6'd19, '0);
      step("R3", 0, ON, 0, 2'b11, 0, 6'd19, '0);
   endtask

   task automatic t_stall();
      step("R3", 0, ON, 0, 2'b11, 0, 6'd20, '0);
      step("R2", 1, 3'b111, 1, 2'b00, 0, 6'd0, 18'h3_FFFF);
      step("R2", 1, ON, 1, 2'b00, 1, 6'd1, 18'h3_FFFF);
      step("R4", 0, ON, 1, 2'b00, 0, 6'd21, '0);
      step("R2", 1, ON, 0, 2'b00, 0, 6'd0, 18'h2_2222);
      step("R4", 0, ON, 0, 2'b00, 0, 6'd21, 18'h1_7171);
   endtask

   task automatic t_burst();
      step("R6", 0, ON, 1, 2'b00, 0, 6'h1E, '0);
      step("R6", 0, ON, 0, 2'b00, 1, 6'h00, 18'h0_1111);
      step("R6", 0, ON, 0, 2'b00, 1, 6'h00, 18'h0_2222);
      step("R6", 0, ON, 0, 2'b00, 1, 6'h00, 18'h0_3333);
      step("R7", 0, ON, 0, 2'b00, 0, 6'h1E, 18'h0_4444);
      for (int i = 0; i < 3; i++) step("R7", 0, ON, 1, 2'b00, 1, 6'h00, '0);
      chk("R7 beat order", ref_mem[int'(6'h1C)], 18'h0_3333);
   endtask

   task automatic t_cont_desel();
      step("R11", 0, 3'b110, 1, 2'b00, 0, 6'h30, '0);
      step("R11", 0, 3'b110, 1, 2'b00, 1, 6'h00, 18'h2_DEAD);
      step("R11", 0, 3'b110, 1, 2'b00, 1, 6'h00, 18'h2_BEEF);
      step("R8", 0, ON, 0, 2'b11, 0, 6'h30, 18'h2_0F0F);
      step("R11", 0, ON, 0, 2'b11, 1, 6'h00, '0);
      step("R11", 0, ON, 0, 2'b11, 0, 6'h30, '0);
   endtask

   task automatic t_sleep();
      step("R12", 0, ON, 0, 2'b11, 0, 6'h02, '0);
      step("R12", 0, ON, 1, 2'b00, 0, 6'h02, '0);
      sleep = 1'b1;
      #1 observe("R12 sleep");
      step("R12", 0, ON, 0, 2'b00, 0, 6'h03, 18'h1_5555);
      step("R12", 0, ON, 1, 2'b00, 0, 6'h02, 18'h1_6666);
      sleep = 1'b0;
      step("R12", 0, ON, 0, 2'b11, 0, 6'h02, 18'h1_7777);
      step("R12", 0, ON, 0, 2'b11, 0, 6'h02, '0);
      chk("R12 kept", rdata, pat(2));
   endtask

   task automatic t_random();
      for (int n = 0; n < 400; n++) begin
         step("R9 mix", ($urandom % 5) == 0, ON, 1'($urandom), 2'($urandom),
              ($urandom % 4) == 0, 6'($urandom), 18'($urandom));
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill();
      t_lanes();
      t_raw();
      t_drive();
      t_desel();
      t_stall();
      t_burst();
      t_cont_desel();
      t_sleep();
      t_random();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule